// File: doc/BRIEF.md
# VRAM Rectangle Transfer Sequencer

This block moves a rectangle of 16-bit pixels between a 32-bit word stream and a 1024 x 512 pixel frame store. A one-cycle `start` pulse loads the rectangle's origin from a position word and its extent from a size word. A direction flag is sampled with the pulse. In write direction the block accepts words on a valid/ready input stream and issues one pixel write per cycle. In read direction it issues one pixel read per cycle and packs the returned pixels into words on a valid/ready output stream. The frame store is outside the block. The block only produces pixel coordinates and strobes. In read direction the store must return `px_rdata` combinationally in the same cycle as `px_re`.

Pixels run in raster order: left to right along a row, then down to the next row. The pixel stream is continuous across word boundaries and across any gap in the input or output stream. This allows a host to deliver a rectangle in bursts of any length, including bursts that end in the middle of a row. The block keeps the column offset inside the current row, the current row and the count of rows still to go.

Back-pressure follows these rules:
- `in_ready` falls whenever the block holds an unfinished word or has no rows left, so words offered after completion stay with the sender.
- On the output side, a word on `out_valid` is held unchanged until `out_ready` takes it.
- While the output slot is full and not draining, the block stops issuing pixel reads.

Top module: `vram_rect_seq`

## Requirements
- R1: After reset `done` is 1, while `in_ready`, `px_we`, `px_re`, `out_valid` and `anomaly` are 0 and `word_count` is 0.
- R2: On `start` the origin column is taken from `pos_word[9:0]` and the origin row from `pos_word[24:16]`; the width is taken from `size_word[15:0]` and the row count from `size_word[31:16]`; all other bits of `pos_word` are ignored.
- R3: In write direction (`start_read`=0) each accepted word produces two pixel writes on consecutive pixel slots, `in_data[15:0]` first and then `in_data[31:16]`, in raster order, at most one strobe per cycle.
- R4: After `width` pixels of a row, the column offset returns to 0, the row advances by one and the remaining row count drops by one; a pause in the stream at any word resumes at origin column plus the kept offset.
- R5: The row address wraps modulo 512 and the column address (origin plus offset) wraps modulo 1024.
- R6: `done` is 1 exactly when no rows remain; while `done` is 1, `in_ready` is 0 and further words are not accepted; when the pixel total is odd the upper half of the final word is discarded.
- R7: `word_count` counts the words moved since the last `start` and ends at ceil(width x rows / 2).
- R8: In read direction (`start_read`=1) pixels are packed two per word, earlier pixel in `out_data[15:0]`; an odd final pixel is sent with `out_data[31:16]`=0; `out_data` stays stable while `out_valid` is 1 and `out_ready` is 0.
- R9: A `start` while rows still remain raises `anomaly` for one cycle, in the cycle after the pulse, and the new transfer replaces the old one; a `start` with no rows left leaves `anomaly` at 0.
- R10: A width of 0 or a row count of 0 leaves `done` at 1 with no pixel strobes and no words accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse loading a new rectangle |
| start_read | input | 1 | Direction sampled with `start`: 1 read, 0 write |
| pos_word | input | 32 | Origin: column in [9:0], row in [24:16] |
| size_word | input | 32 | Extent: width in [15:0], rows in [31:16] |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken on this edge if valid |
| in_data | input | 32 | Two pixels to write, low half first |
| out_valid | output | 1 | Packed read word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Two read pixels, earlier in low half |
| px_x | output | 10 | Pixel column address |
| px_y | output | 9 | Pixel row address |
| px_we | output | 1 | Pixel write strobe |
| px_re | output | 1 | Pixel read strobe |
| px_wdata | output | 16 | Pixel write data |
| px_rdata | input | 16 | Pixel read data, valid in the `px_re` cycle |
| done | output | 1 | No rows remain |
| anomaly | output | 1 | Restart while a transfer was unfinished |
| word_count | output | 32 | Words moved since the last start |

## Verification
The bench delivers rectangles in bursts as short as one word. Odd widths then make bursts end mid-row and mid-word. A design that drops the kept offset would restart rows at the origin column, and one that pairs pixels per row would shift data by half a word. Rectangles placed at column 1020 and row 510 cross both address wraps. A design missing either wrap would address outside the store. Two extra words are offered after every rectangle, and odd pixel totals are used, to catch a block that swallows surplus words or miscounts the final half word. The read path is driven with an irregular `out_ready` to expose a word that changes while stalled. A restart in mid-transfer and zero-sized rectangles cover the anomaly flag and the immediate-completion case.

// File: rtl/vram_rect_pkg.sv
package vram_rect_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;

  localparam int PIX_PER_WORD = 2;

endpackage

// File: rtl/vram_rect_cursor.sv
module vram_rect_cursor #(
  parameter int COL_W = 10,
  parameter int ROW_W = 9,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] ld_x,
  input  logic [ROW_W-1:0] ld_y,
  input  logic [EXT_W-1:0] ld_w,
  input  logic [EXT_W-1:0] ld_h,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             busy,
  output logic             last_px
);

  logic [COL_W-1:0] x0_q;
  logic [ROW_W-1:0] y_q;
  logic [EXT_W-1:0] w_q;
  logic [EXT_W-1:0] off_q;
  logic [EXT_W-1:0] hrem_q;
  logic [EXT_W-1:0] off_nxt;
  logic             row_end;

  assign off_nxt = off_q + EXT_W'(1);
  assign row_end = (off_nxt == w_q);
  assign busy    = (hrem_q != '0);
  assign last_px = busy && row_end && (hrem_q == EXT_W'(1));
  // column wraps by truncation of the sum
  assign col     = x0_q + off_q[COL_W-1:0];
  assign row     = y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q   <= '0;
      y_q    <= '0;
      w_q    <= '0;
      off_q  <= '0;
      hrem_q <= '0;
    end else if (load) begin
      x0_q   <= ld_x;
      y_q    <= ld_y;
      w_q    <= ld_w;
      off_q  <= '0;
      hrem_q <= (ld_w == '0) ? '0 : ld_h;
    end else if (step && busy) begin
      if (row_end) begin
        off_q  <= '0;
        y_q    <= y_q + ROW_W'(1);
        hrem_q <= hrem_q - EXT_W'(1);
      end else begin
        off_q  <= off_nxt;
      end
    end
  end

endmodule

// File: rtl/vram_rect_unpack.sv
module vram_rect_unpack #(
  parameter int PIX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               active,
  input  logic               last_px,
  input  logic               in_valid,
  input  logic [2*PIX_W-1:0] in_data,
  output logic               in_ready,
  output logic               px_fire,
  output logic [PIX_W-1:0]   px_data
);

  logic [2*PIX_W-1:0] word_q;
  logic [1:0]         npx_q;
  logic               accept;

  assign px_fire  = active && (npx_q != 2'd0);
  assign in_ready = active && ((npx_q == 2'd0) || ((npx_q == 2'd1) && !last_px));
  assign accept   = in_valid && in_ready;
  assign px_data  = word_q[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      npx_q  <= 2'd0;
    end else if (clear) begin
      npx_q  <= 2'd0;
    end else if (accept) begin
      word_q <= in_data;
      npx_q  <= 2'd2;
    end else if (px_fire) begin
      if (last_px) begin
        npx_q  <= 2'd0;
      end else begin
        npx_q  <= npx_q - 2'd1;
        word_q <= word_q >> PIX_W;
      end
    end
  end

endmodule

// File: rtl/vram_rect_pack.sv
module vram_rect_pack #(
  parameter int PIX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               active,
  input  logic               last_px,
  input  logic [PIX_W-1:0]   px_rdata,
  output logic               px_take,
  output logic               word_emit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*PIX_W-1:0] out_data
);

  logic               have_lo_q;
  logic [PIX_W-1:0]   lo_q;
  logic               ov_q;
  logic [2*PIX_W-1:0] od_q;
  logic               slot_ok;
  logic               completes;

  assign slot_ok   = !ov_q || out_ready;
  assign completes = have_lo_q || last_px;
  assign px_take   = active && (!completes || slot_ok);
  assign word_emit = px_take && completes;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo_q <= 1'b0;
      lo_q      <= '0;
      ov_q      <= 1'b0;
      od_q      <= '0;
    end else if (clear) begin
      have_lo_q <= 1'b0;
      ov_q      <= 1'b0;
    end else if (word_emit) begin
      ov_q      <= 1'b1;
      od_q      <= have_lo_q ? {px_rdata, lo_q} : {{PIX_W{1'b0}}, px_rdata};
      have_lo_q <= 1'b0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (px_take) begin
        have_lo_q <= 1'b1;
        lo_q      <= px_rdata;
      end
    end
  end

endmodule

// File: rtl/vram_rect_seq.sv
module vram_rect_seq
  import vram_rect_pkg::*;
#(
  parameter int COLS  = 1024,
  parameter int ROWS  = 512,
  parameter int EXT_W = 16,
  parameter int PIX_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              start_read,
  input  logic [PIX_PER_WORD*PIX_W-1:0]     pos_word,
  input  logic [PIX_PER_WORD*PIX_W-1:0]     size_word,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [PIX_PER_WORD*PIX_W-1:0]     in_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [PIX_PER_WORD*PIX_W-1:0]     out_data,
  output logic [$clog2(COLS)-1:0]           px_x,
  output logic [$clog2(ROWS)-1:0]           px_y,
  output logic                              px_we,
  output logic                              px_re,
  output logic [PIX_W-1:0]                  px_wdata,
  input  logic [PIX_W-1:0]                  px_rdata,
  output logic                              done,
  output logic                              anomaly,
  output logic [2*EXT_W-1:0]                word_count
);

  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int WORD_W = PIX_PER_WORD * PIX_W;
  localparam int HI_LSB = WORD_W / 2;
  localparam int CNT_W  = 2 * EXT_W;

  xfer_dir_e        dir_q;
  logic             busy;
  logic             last_px;
  logic             wr_active;
  logic             rd_active;
  logic             wr_fire;
  logic             rd_take;
  logic             word_emit;
  logic             anomaly_q;
  logic [CNT_W-1:0] wcnt_q;
  logic             unused_pos_bits;

  assign unused_pos_bits = ^{pos_word[WORD_W-1:HI_LSB+ROW_W], pos_word[HI_LSB-1:COL_W]};

  assign wr_active = busy && (dir_q == DIR_WRITE) && !start;
  assign rd_active = busy && (dir_q == DIR_READ) && !start;

  vram_rect_cursor #(
    .COL_W(COL_W),
    .ROW_W(ROW_W),
    .EXT_W(EXT_W)
  ) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .ld_x    (pos_word[COL_W-1:0]),
    .ld_y    (pos_word[HI_LSB +: ROW_W]),
    .ld_w    (size_word[EXT_W-1:0]),
    .ld_h    (size_word[HI_LSB +: EXT_W]),
    .step    (wr_fire || rd_take),
    .col     (px_x),
    .row     (px_y),
    .busy    (busy),
    .last_px (last_px)
  );

  vram_rect_unpack #(
    .PIX_W(PIX_W)
  ) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .active   (wr_active),
    .last_px  (last_px),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .px_fire  (wr_fire),
    .px_data  (px_wdata)
  );

  vram_rect_pack #(
    .PIX_W(PIX_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .active    (rd_active),
    .last_px   (last_px),
    .px_rdata  (px_rdata),
    .px_take   (rd_take),
    .word_emit (word_emit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= DIR_WRITE;
      anomaly_q <= 1'b0;
      wcnt_q    <= '0;
    end else begin
      anomaly_q <= start && busy;
      if (start) begin
        dir_q  <= start_read ? DIR_READ : DIR_WRITE;
        wcnt_q <= '0;
      end else if ((in_valid && in_ready) || word_emit) begin
        wcnt_q <= wcnt_q + CNT_W'(1);
      end
    end
  end

  assign px_we      = wr_fire;
  assign px_re      = rd_take;
  assign done       = !busy;
  assign anomaly    = anomaly_q;
  assign word_count = wcnt_q;

endmodule

// File: rtl/vram_rect_seq_chk.sv
module vram_rect_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic              done,
  input logic              px_we,
  input logic              px_re,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              anomaly
);

  // R6: nothing is accepted once no rows remain
  a_r6_no_ready_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R10: a finished or empty rectangle issues no pixel strobes
  a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(px_we || px_re));

  // R3: never a write and a read strobe together
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(px_we && px_re));

  // R8: a stalled output word holds its value
  a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R9: the flag only follows a start pulse
  a_r9_anomaly_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> $past(start));

endmodule

bind vram_rect_seq vram_rect_seq_chk #(.WORD_W(32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .done      (done),
  .px_we     (px_we),
  .px_re     (px_re),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .anomaly   (anomaly)
);

// File: tb/tb_vram_rect_seq.sv
module tb_vram_rect_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // x, y, width, rows, burst words, gap cycles
  localparam int VEC [NVEC][6] = '{
    '{5,    7,   4, 3, 100, 0},
    '{100,  20,  3, 3, 1,   2},
    '{1020, 510, 8, 4, 3,   1},
    '{0,    0,   1, 5, 2,   3},
    '{200,  300, 7, 2, 4,   0},
    '{50,   511, 5, 1, 2,   1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_read = 1'b0;
  logic [31:0] pos_word = '0;
  logic [31:0] size_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [9:0]  px_x;
  logic [8:0]  px_y;
  logic        px_we;
  logic        px_re;
  logic [15:0] px_wdata;
  logic [15:0] px_rdata;
  logic        done;
  logic        anomaly;
  logic [31:0] word_count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int mx0, my0, mw, mp, mseed, merr;
  bit mon_on = 1'b0;
  int strobe_cnt = 0;
  bit collect_on = 1'b0;
  logic [31:0] rd_words [64];
  int rd_n = 0;
  int stall_err = 0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic last_anom = 1'b0;

  assign px_rdata = {px_y[5:0], px_x};

  vram_rect_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_read(start_read),
    .pos_word(pos_word), .size_word(size_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .px_x(px_x), .px_y(px_y), .px_we(px_we), .px_re(px_re),
    .px_wdata(px_wdata), .px_rdata(px_rdata),
    .done(done), .anomaly(anomaly), .word_count(word_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] pix(input int s, input int n);
    return 16'(s + n);
  endfunction

  function automatic logic [15:0] rdpix(input int x, input int y, input int w, input int p);
    int c, r;
    c = (x + p % w) % 1024;
    r = (y + p / w) % 512;
    return {6'(r), 10'(c)};
  endfunction

  always @(negedge clk) begin
    int ex_x, ex_y;
    if (px_we || px_re) strobe_cnt++;
    if (mon_on && (px_we || px_re) && mw > 0) begin
      ex_x = (mx0 + mp % mw) % 1024;
      ex_y = (my0 + mp / mw) % 512;
      if (px_x != 10'(ex_x) || px_y != 9'(ex_y)) merr++;
      if (px_we && px_wdata != pix(mseed, mp)) merr++;
      mp++;
    end
    if (collect_on) begin
      if (prev_stall && (!out_valid || out_data != prev_data)) stall_err++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready && rd_n < 64) begin
        rd_words[rd_n] = out_data;
        rd_n++;
      end
    end
  end

  task automatic chk(input string msg, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic issue_start(input int x, input int y, input int w, input int h, input bit rd);
    @(posedge clk); #1;
    pos_word   = {7'h55, 9'(y), 6'h2a, 10'(x)};
    size_word  = {16'(h), 16'(w)};
    start_read = rd;
    start      = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_write(input int x, input int y, input int w, input int h,
                           input int burst, input int gap, input int seed, input string tag);
    int npx, nw, acc, inburst, guard;
    bit a;
    issue_start(x, y, w, h, 1'b0);
    mx0 = x; my0 = y; mw = w; mp = 0; mseed = seed; merr = 0; mon_on = 1'b1;
    @(negedge clk);
    last_anom = anomaly;
    @(posedge clk); #1;
    npx = w * h;
    nw = (npx + 1) / 2;
    acc = 0;
    inburst = 0;
    for (int k = 0; k < nw + 2; k++) begin
      in_data  = {pix(seed, 2*k + 1), pix(seed, 2*k)};
      in_valid = 1'b1;
      guard = 0;
      a = 1'b0;
      while (!a && guard < 50) begin
        @(negedge clk);
        a = in_ready;
        @(posedge clk); #1;
        guard++;
      end
      in_valid = 1'b0;
      if (!a) break;
      acc++;
      inburst++;
      if (inburst == burst) begin
        inburst = 0;
        if (gap > 0) begin
          repeat (gap) @(posedge clk);
          #1;
        end
      end
    end
    repeat (3) @(posedge clk);
    #1;
    mon_on = 1'b0;
    @(negedge clk);
    chk({tag, " R3 R4 R5 pixel address/data mismatches"}, merr, 0);
    chk({tag, " R4 pixels written"}, mp, npx);
    chk({tag, " R6 words accepted (surplus refused)"}, acc, nw);
    chk({tag, " R7 word_count"}, word_count, nw);
    chk({tag, " R6 done at end"}, done, 1);
  endtask

  task automatic run_read(input int x, input int y, input int w, input int h, input string tag);
    int npx, nw, werr;
    logic [15:0] lo, hi;
    issue_start(x, y, w, h, 1'b1);
    mx0 = x; my0 = y; mw = w; mp = 0; mseed = 0; merr = 0; mon_on = 1'b1;
    rd_n = 0; stall_err = 0; prev_stall = 1'b0; collect_on = 1'b1;
    npx = w * h;
    nw = (npx + 1) / 2;
    for (int i = 0; i < 400 && !(done && rd_n == nw); i++) begin
      @(posedge clk); #1;
      out_ready = (i % 3 != 2);
    end
    out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    out_ready = 1'b0;
    mon_on = 1'b0;
    collect_on = 1'b0;
    werr = 0;
    for (int k = 0; k < nw && k < rd_n; k++) begin
      lo = rdpix(x, y, w, 2*k);
      hi = (2*k + 1 < npx) ? rdpix(x, y, w, 2*k + 1) : 16'h0;
      if (rd_words[k] != {hi, lo}) werr++;
    end
    @(negedge clk);
    chk({tag, " R8 R5 read address mismatches"}, merr, 0);
    chk({tag, " R8 words delivered"}, rd_n, nw);
    chk({tag, " R8 packed word mismatches"}, werr, 0);
    chk({tag, " R8 stalled word changed"}, stall_err, 0);
    chk({tag, " R7 word_count read"}, word_count, nw);
  endtask

  initial begin
    int sc;
    bit a;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done after reset", done, 1);
    chk("R1 in_ready after reset", in_ready, 0);
    chk("R1 strobes after reset", {px_we, px_re}, 0);
    chk("R1 out_valid/anomaly after reset", {out_valid, anomaly}, 0);
    chk("R1 word_count after reset", word_count, 0);

    // table of write rectangles; R2 via garbage bits in pos_word
    for (int v = 0; v < NVEC; v++) begin
      run_write(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                1000 * (v + 1), $sformatf("R2 vec%0d", v));
      chk($sformatf("vec%0d R9 no anomaly on idle start", v), last_anom, 0);
    end

    // R9 restart mid-transfer
    issue_start(0, 0, 4, 2, 1'b0);
    in_data = 32'hdead_beef;
    in_valid = 1'b1;
    a = 1'b0;
    for (int g = 0; g < 10 && !a; g++) begin
      @(negedge clk);
      a = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    run_write(30, 40, 3, 2, 2, 0, 7777, "R9 restart");
    chk("R9 anomaly on restart", last_anom, 1);

    // R8 read direction
    run_read(10, 5, 3, 3, "rd odd");
    run_read(1022, 511, 4, 2, "rd wrap");

    // R10 zero width
    issue_start(3, 3, 0, 3, 1'b0);
    @(negedge clk);
    chk("R10 done with zero width", done, 1);
    sc = strobe_cnt;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data = 32'h1234_5678;
    repeat (5) @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 no strobes with zero width", strobe_cnt - sc, 0);
    chk("R10 no words accepted", word_count, 0);

    // R10 zero rows
    issue_start(3, 3, 5, 0, 1'b1);
    sc = strobe_cnt;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 done with zero rows", done, 1);
    chk("R10 no read strobes with zero rows", strobe_cnt - sc, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule